// File: doc/BRIEF.md
# Logical Address Routing Table

This block holds the routing decision for every logical address that can open a packet on a switch with ten output ports. A configuration master writes and reads one 32-bit word per logical address through a simple register port. The switch's input side presents the first header byte of each packet on a lookup port. The table answers with the set of output ports the packet may contend for, whether the header byte is to be stripped, whether the packet is high priority, and whether the address is unusable.

Header values below 32 are path addresses. This table does not serve them, so the block only flags them as not logical. When a lookup hits an entry marked invalid, the block asks for the packet to be spilled and emits a one-cycle address-error pulse for the port status logic. When several port bits are set in an entry, the arbiter may route the packet adaptively to any of those ports. Port 0 is the configuration port and can never be reached through this table.

Top module: `rt_logical_table`

## Requirements
- R1: Configuration addresses 32 to 255 each hold one entry. A read returns the stored word combinationally in the same cycle. Reads of addresses 0 to 31 return zero, and writes to those addresses change no entry.
- R2: Entry word layout: bits 10:1 are the port mask (bit n selects output port n, for n = 1 to 10). Bit 29 is delete-header, bit 30 is priority and bit 31 is invalid. Bit 0 and bits 28:11 always read as zero, whatever was written to them.
- R3: A write whose bits 10:1 are all zero stores the word 0x8000_0000 (invalid set, every other field cleared), whatever else the write data held.
- R4: Reset sets the invalid bit of every entry to 1 and leaves the port mask, delete-header and priority fields unchanged.
- R5: A lookup presented with `hdr_valid` high gives its result, with `res_valid` high, in the following cycle. `res_valid` is low in the cycle after a clock edge at which `hdr_valid` was low.
- R6: A lookup of a header byte of 32 or more that hits a valid entry returns the entry's port mask unchanged, including masks with several bits set, together with its delete-header and priority flags. `res_invalid`, `res_spill` and `res_addr_err` are low.
- R7: A lookup that hits an invalid entry raises `res_invalid`, `res_spill` and `res_addr_err` for exactly one result cycle. Port mask, delete-header and priority are zero.
- R8: A lookup of a header byte below 32 raises `res_not_logical`. Port mask, invalid, spill and address error are zero.
- R9: A write and a lookup to the same entry in the same cycle return the entry's old contents. The new contents are returned by the next lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr_en | input | 1 | Write strobe for the configuration port |
| cfg_addr | input | 8 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Configuration read data for `cfg_addr` |
| hdr_valid | input | 1 | A header byte is presented for lookup |
| hdr_byte | input | 8 | First header byte of the packet |
| res_valid | output | 1 | Lookup result valid |
| res_port_mask | output | 10 | Allowed output ports; bit i is port i+1 |
| res_del_hdr | output | 1 | Strip the header byte before forwarding |
| res_priority | output | 1 | Packet is high priority |
| res_invalid | output | 1 | Looked-up entry is invalid |
| res_not_logical | output | 1 | Header byte is below 32 |
| res_spill | output | 1 | Packet must be spilled |
| res_addr_err | output | 1 | One-cycle address-error pulse |

## Verification
Lookups are tried with single-port entries at the lowest and highest logical addresses, with a full ten-port adaptive mask, and with entries that were never written after reset. The full-port case separates pass-through of the mask from any port selection. Zero-mask writes, all-ones writes, and writes below address 32 show whether write sanitising and the address window are correct. A write and a lookup to the same entry in the same cycle show whether old data or new data is returned. A reset in the middle of the run shows that only the invalid bit is touched. Runs of back-to-back lookups that mix path addresses, invalid entries and valid entries show whether results are ever carried over from one cycle to the next.

// File: rtl/rt_pkg.sv
package rt_pkg;
  localparam int RT_PORTS   = 10;
  localparam int RT_ADDR_W  = 8;
  localparam int RT_DATA_W  = 32;
  localparam int RT_FIRST   = 32;
  localparam int RT_ENTRIES = (1 << RT_ADDR_W) - RT_FIRST;
  localparam int RT_IDX_W   = $clog2(RT_ENTRIES);

  localparam int MASK_LSB = 1;
  localparam int DEL_BIT  = 29;
  localparam int PRI_BIT  = 30;
  localparam int INV_BIT  = 31;

  typedef struct packed {
    logic                inv;
    logic                pri;
    logic                del;
    logic [RT_PORTS-1:0] mask;
  } rt_entry_t;

  typedef struct packed {
    logic                valid;
    logic [RT_PORTS-1:0] mask;
    logic                del;
    logic                pri;
    logic                inv;
    logic                not_logical;
    logic                spill;
    logic                addr_err;
  } rt_result_t;

  // Write-side cleanup: an empty mask forces the canonical invalid entry
  function automatic rt_entry_t rt_sanitize(input logic [RT_DATA_W-1:0] w);
    rt_entry_t e;
    e.mask = w[MASK_LSB +: RT_PORTS];
    if (e.mask == '0) begin
      e.inv = 1'b1;
      e.pri = 1'b0;
      e.del = 1'b0;
    end else begin
      e.inv = w[INV_BIT];
      e.pri = w[PRI_BIT];
      e.del = w[DEL_BIT];
    end
    return e;
  endfunction

  // Entry to register word; unused bit positions stay zero
  function automatic logic [RT_DATA_W-1:0] rt_pack(input rt_entry_t e);
    logic [RT_DATA_W-1:0] w;
    w = '0;
    w[MASK_LSB +: RT_PORTS] = e.mask;
    w[DEL_BIT] = e.del;
    w[PRI_BIT] = e.pri;
    w[INV_BIT] = e.inv;
    return w;
  endfunction

  function automatic logic rt_is_logical(input logic [RT_ADDR_W-1:0] a);
    return a >= RT_ADDR_W'(RT_FIRST);
  endfunction

  function automatic logic [RT_IDX_W-1:0] rt_index(input logic [RT_ADDR_W-1:0] a);
    logic [RT_ADDR_W-1:0] d;
    d = a - RT_ADDR_W'(RT_FIRST);
    return RT_IDX_W'(d);
  endfunction
endpackage

// File: rtl/rt_entry_store.sv
module rt_entry_store
  import rt_pkg::*;
#(
  parameter int ENTRIES = RT_ENTRIES,
  localparam int IW = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      wr_en,
  input  logic [IW-1:0] wr_idx,
  input  rt_entry_t wr_entry,
  input  logic [IW-1:0] rd_a_idx,
  output rt_entry_t rd_a_entry,
  input  logic [IW-1:0] rd_b_idx,
  output rt_entry_t rd_b_entry
);
  logic [ENTRIES-1:0]  inv_q;
  logic [RT_PORTS-1:0] mask_q [ENTRIES];
  logic [ENTRIES-1:0]  del_q;
  logic [ENTRIES-1:0]  pri_q;

  // Only the invalid flags are reset; the other fields keep their contents
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     inv_q <= '1;
    else if (wr_en) inv_q[wr_idx] <= wr_entry.inv;
  end

  always_ff @(posedge clk) begin
    if (wr_en && rst_n) begin
      mask_q[wr_idx] <= wr_entry.mask;
      del_q[wr_idx]  <= wr_entry.del;
      pri_q[wr_idx]  <= wr_entry.pri;
    end
  end

  always_comb begin
    rd_a_entry.inv  = inv_q[rd_a_idx];
    rd_a_entry.pri  = pri_q[rd_a_idx];
    rd_a_entry.del  = del_q[rd_a_idx];
    rd_a_entry.mask = mask_q[rd_a_idx];
    rd_b_entry.inv  = inv_q[rd_b_idx];
    rd_b_entry.pri  = pri_q[rd_b_idx];
    rd_b_entry.del  = del_q[rd_b_idx];
    rd_b_entry.mask = mask_q[rd_b_idx];
  end

  // R3: a sanitised write lands exactly as presented
  assert_store_write_R3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (inv_q[$past(wr_idx)] == $past(wr_entry.inv)) &&
              (mask_q[$past(wr_idx)] == $past(wr_entry.mask)));
endmodule

// File: rtl/rt_lookup.sv
module rt_lookup
  import rt_pkg::*;
#(
  parameter bit REGISTERED = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       hdr_valid,
  input  logic       hdr_logical,
  input  rt_entry_t  entry,
  output rt_result_t result
);
  rt_result_t now_res;
  logic       ev_hit;
  logic       ev_bad;

  assign ev_hit = hdr_valid && hdr_logical && !entry.inv;
  assign ev_bad = hdr_valid && hdr_logical &&  entry.inv;

  always_comb begin
    now_res.valid       = hdr_valid;
    now_res.mask        = ev_hit ? entry.mask : '0;
    now_res.del         = ev_hit && entry.del;
    now_res.pri         = ev_hit && entry.pri;
    now_res.inv         = ev_bad;
    now_res.not_logical = hdr_valid && !hdr_logical;
    now_res.spill       = ev_bad;
    now_res.addr_err    = ev_bad;
  end

  generate
    if (REGISTERED) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) result <= '0;
        else        result <= now_res;
      end
      // R5: one-cycle latency from request to result
      assert_latency_R5: assert property (@(posedge clk) disable iff (!rst_n)
        hdr_valid |=> result.valid);
      assert_idle_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !hdr_valid |=> !result.valid);
      // R7: the error pulse does not repeat without a new request
      assert_err_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (result.addr_err && !hdr_valid) |=> !result.addr_err);
    end else begin : g_comb
      assign result = now_res;
    end
  endgenerate

  // R7: error outputs travel together and carry no routing
  assert_err_shape_R7: assert property (@(posedge clk) disable iff (!rst_n)
    result.addr_err |-> result.valid && result.inv && result.spill &&
                        result.mask == '0 && !result.del && !result.pri);
  // R8: a path address never reads the table
  assert_not_logical_R8: assert property (@(posedge clk) disable iff (!rst_n)
    result.not_logical |-> !result.spill && !result.inv && result.mask == '0);
  // R6: a routed result always names at least one port
  assert_routed_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (result.valid && !result.inv && !result.not_logical) |-> result.mask != '0);
endmodule

// File: rtl/rt_logical_table.sv
module rt_logical_table
  import rt_pkg::*;
#(
  parameter bit LOOKUP_REG = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 cfg_wr_en,
  input  logic [RT_ADDR_W-1:0] cfg_addr,
  input  logic [RT_DATA_W-1:0] cfg_wdata,
  output logic [RT_DATA_W-1:0] cfg_rdata,
  input  logic                 hdr_valid,
  input  logic [RT_ADDR_W-1:0] hdr_byte,
  output logic                 res_valid,
  output logic [RT_PORTS-1:0]  res_port_mask,
  output logic                 res_del_hdr,
  output logic                 res_priority,
  output logic                 res_invalid,
  output logic                 res_not_logical,
  output logic                 res_spill,
  output logic                 res_addr_err
);
  logic                cfg_in_table;
  logic [RT_IDX_W-1:0] cfg_idx;
  logic                ev_wr_table;
  logic                ev_wr_zero;
  rt_entry_t           wr_entry;
  rt_entry_t           cfg_entry;
  logic                hdr_logical;
  logic [RT_IDX_W-1:0] hdr_idx;
  rt_entry_t           hdr_entry;
  rt_result_t          result;

  assign cfg_in_table = rt_is_logical(cfg_addr);
  assign cfg_idx      = cfg_in_table ? rt_index(cfg_addr) : '0;
  assign ev_wr_table  = cfg_wr_en && cfg_in_table;
  assign ev_wr_zero   = ev_wr_table && (cfg_wdata[MASK_LSB +: RT_PORTS] == '0);
  assign wr_entry     = rt_sanitize(cfg_wdata);
  assign cfg_rdata    = cfg_in_table ? rt_pack(cfg_entry) : '0;

  assign hdr_logical  = rt_is_logical(hdr_byte);
  assign hdr_idx      = hdr_logical ? rt_index(hdr_byte) : '0;

  rt_entry_store #(.ENTRIES(RT_ENTRIES)) u_store (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (ev_wr_table),
    .wr_idx     (cfg_idx),
    .wr_entry   (wr_entry),
    .rd_a_idx   (cfg_idx),
    .rd_a_entry (cfg_entry),
    .rd_b_idx   (hdr_idx),
    .rd_b_entry (hdr_entry)
  );

  rt_lookup #(.REGISTERED(LOOKUP_REG)) u_lookup (
    .clk         (clk),
    .rst_n       (rst_n),
    .hdr_valid   (hdr_valid),
    .hdr_logical (hdr_logical),
    .entry       (hdr_entry),
    .result      (result)
  );

  assign res_valid       = result.valid;
  assign res_port_mask   = result.mask;
  assign res_del_hdr     = result.del;
  assign res_priority    = result.pri;
  assign res_invalid     = result.inv;
  assign res_not_logical = result.not_logical;
  assign res_spill       = result.spill;
  assign res_addr_err    = result.addr_err;

  // R3: an empty mask yields the canonical invalid entry at the store input
  assert_zero_mask_R3: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wr_zero |-> wr_entry.inv && !wr_entry.del && !wr_entry.pri);
  // R1: path-address window reads as zero
  assert_window_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_in_table |-> cfg_rdata == '0);
  // R2: reserved bit positions never read back set
  assert_reserved_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_rdata[0] == 1'b0 && cfg_rdata[DEL_BIT-1:MASK_LSB+RT_PORTS] == '0);
endmodule

// File: tb/rt_logical_table_test.sv
module rt_logical_table_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_wr_en = 1'b0;
  logic [7:0]  cfg_addr = '0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        hdr_valid = 1'b0;
  logic [7:0]  hdr_byte = '0;
  logic        res_valid, res_del_hdr, res_priority, res_invalid;
  logic        res_not_logical, res_spill, res_addr_err;
  logic [9:0]  res_port_mask;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #5 clk = ~clk;

  rt_logical_table uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr_en(cfg_wr_en), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .hdr_valid(hdr_valid),
    .hdr_byte(hdr_byte), .res_valid(res_valid), .res_port_mask(res_port_mask),
    .res_del_hdr(res_del_hdr), .res_priority(res_priority),
    .res_invalid(res_invalid), .res_not_logical(res_not_logical),
    .res_spill(res_spill), .res_addr_err(res_addr_err)
  );

  // Behavioural reference: one record per configuration address
  int unsigned m_mask  [256];
  bit          m_del   [256];
  bit          m_pri   [256];
  bit          m_inv   [256];
  bit          m_known [256];
  bit          e_valid, e_del, e_pri, e_inv, e_nl, e_bad;
  int unsigned e_mask;

  initial begin
    for (int i = 0; i < 256; i++) begin
      m_inv[i] = 1; m_known[i] = 0; m_mask[i] = 0; m_del[i] = 0; m_pri[i] = 0;
    end
    e_valid = 0; e_del = 0; e_pri = 0; e_inv = 0; e_nl = 0; e_bad = 0; e_mask = 0;
  end

  always @(negedge rst_n) begin
    for (int i = 0; i < 256; i++) m_inv[i] = 1;   // R4: only invalid flags change
    e_valid = 0; e_del = 0; e_pri = 0; e_inv = 0; e_nl = 0; e_bad = 0; e_mask = 0;
  end

  always @(posedge clk) begin
    if (rst_n) begin
      int h;
      h = hdr_byte;
      // lookup first, so a same-cycle write is not yet seen (R9)
      e_valid = hdr_valid;
      e_nl    = hdr_valid && h < 32;
      e_bad   = hdr_valid && h >= 32 && m_inv[h];
      e_inv   = e_bad;
      if (hdr_valid && h >= 32 && !m_inv[h]) begin
        e_mask = m_mask[h]; e_del = m_del[h]; e_pri = m_pri[h];
      end else begin
        e_mask = 0; e_del = 0; e_pri = 0;
      end
      if (cfg_wr_en && cfg_addr >= 32) begin
        int a;
        int unsigned mk;
        a  = cfg_addr;
        mk = (cfg_wdata >> 1) & 32'h3FF;
        m_known[a] = 1;
        m_mask[a]  = mk;
        if (mk == 0) begin
          m_inv[a] = 1; m_del[a] = 0; m_pri[a] = 0;
        end else begin
          m_inv[a] = cfg_wdata[31]; m_pri[a] = cfg_wdata[30]; m_del[a] = cfg_wdata[29];
        end
      end
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // Every-cycle comparison against the reference, away from the clock edge
  always @(negedge clk) begin
    if (!done) begin
      int a;
      logic [31:0] ew, keep;
      chk("R5", "res_valid", 32'(res_valid), 32'(e_valid));
      chk("R6", "res_port_mask", 32'(res_port_mask), e_mask);
      chk("R6", "res_del_hdr", 32'(res_del_hdr), 32'(e_del));
      chk("R6", "res_priority", 32'(res_priority), 32'(e_pri));
      chk("R7", "res_invalid", 32'(res_invalid), 32'(e_inv));
      chk("R7", "res_spill", 32'(res_spill), 32'(e_bad));
      chk("R7", "res_addr_err", 32'(res_addr_err), 32'(e_bad));
      chk("R8", "res_not_logical", 32'(res_not_logical), 32'(e_nl));
      a = cfg_addr;
      if (a < 32) begin
        ew = 0; keep = 32'hFFFF_FFFF;
      end else begin
        ew = {m_inv[a], m_pri[a], m_del[a], 18'b0, m_mask[a][9:0], 1'b0};
        keep = m_known[a] ? 32'hFFFF_FFFF : 32'h9FFF_F801;
      end
      chk("R1", "cfg_rdata", cfg_rdata & keep, ew & keep);
    end
  end

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cfg_wr_en = 1; cfg_addr = a; cfg_wdata = d;
    @(posedge clk); #1;
    cfg_wr_en = 0;
  endtask

  task automatic look(input logic [7:0] h);
    hdr_valid = 1; hdr_byte = h;
    @(posedge clk); #1;
    hdr_valid = 0;
  endtask

  task automatic rd_chk(input logic [7:0] a, input logic [31:0] exp, input string tag);
    cfg_addr = a;
    @(negedge clk);
    chk(tag, "read word", cfg_rdata, exp);
    @(posedge clk); #1;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    chk("R5", "res_valid after reset", 32'(res_valid), 32'h0);
    @(posedge clk); #1;

    wr(8'd32,  32'h2000_0002);           // port 1, delete header
    wr(8'd100, 32'h4000_07FE);           // all ten ports, priority
    wr(8'd255, 32'h0000_0400);           // port 10 only
    wr(8'd40,  32'hFFFF_FFFF);
    rd_chk(8'd40, 32'hE000_07FE, "R2");
    wr(8'd50,  32'h6000_0001);           // empty mask with junk elsewhere
    rd_chk(8'd50, 32'h8000_0000, "R3");
    wr(8'd10,  32'h0000_0004);
    rd_chk(8'd10, 32'h0, "R1");
    rd_chk(8'd32, 32'h2000_0002, "R1");

    look(8'd32);
    @(negedge clk);
    chk("R5", "res_valid", 32'(res_valid), 32'h1);
    chk("R6", "mask port1", 32'(res_port_mask), 32'h001);
    chk("R6", "delete header", 32'(res_del_hdr), 32'h1);
    @(negedge clk);
    chk("R5", "res_valid idle", 32'(res_valid), 32'h0);
    @(posedge clk); #1;
    look(8'd100);
    @(negedge clk);
    chk("R6", "adaptive mask", 32'(res_port_mask), 32'h3FF);
    chk("R6", "priority", 32'(res_priority), 32'h1);
    @(posedge clk); #1;
    look(8'd50);
    @(negedge clk);
    chk("R7", "spill", 32'(res_spill), 32'h1);
    chk("R7", "addr_err", 32'(res_addr_err), 32'h1);
    @(negedge clk);
    chk("R7", "addr_err single pulse", 32'(res_addr_err), 32'h0);
    @(posedge clk); #1;
    look(8'd31);
    @(negedge clk);
    chk("R8", "not logical", 32'(res_not_logical), 32'h1);
    @(posedge clk); #1;

    // back-to-back mixed lookups, checked by the per-cycle comparison
    hdr_valid = 1;
    foreach (hdr_byte_list[i]) begin
      hdr_byte = hdr_byte_list[i];
      @(posedge clk); #1;
    end
    hdr_valid = 0;
    @(posedge clk); #1;

    // R9: same-cycle write and lookup of entry 32
    cfg_wr_en = 1; cfg_addr = 8'd32; cfg_wdata = 32'h0000_0008;
    hdr_valid = 1; hdr_byte = 8'd32;
    @(posedge clk); #1;
    cfg_wr_en = 0; hdr_valid = 0;
    @(negedge clk);
    chk("R9", "old mask", 32'(res_port_mask), 32'h001);
    @(posedge clk); #1;
    look(8'd32);
    @(negedge clk);
    chk("R9", "new mask", 32'(res_port_mask), 32'h004);
    @(posedge clk); #1;

    // R4: reset in mid-run keeps fields, sets invalid
    rst_n = 0;
    repeat (2) @(posedge clk);
    #1 rst_n = 1;
    rd_chk(8'd100, 32'hC000_07FE, "R4");
    rd_chk(8'd255, 32'h8000_0400, "R4");
    look(8'd100);
    @(negedge clk);
    chk("R4", "lookup after reset invalid", 32'(res_invalid), 32'h1);
    chk("R7", "no routing on invalid", 32'(res_port_mask), 32'h0);
    @(posedge clk); #1;
    wr(8'd255, 32'h0000_0400);
    look(8'd255);
    @(negedge clk);
    chk("R6", "mask port10", 32'(res_port_mask), 32'h200);
    @(posedge clk); #1;
    repeat (2) @(posedge clk);
    #1 done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  logic [7:0] hdr_byte_list [10] = '{8'd0, 8'd255, 8'd77, 8'd32, 8'd5,
                                     8'd100, 8'd50, 8'd40, 8'd31, 8'd33};

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      fails++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule